// File: doc/BRIEF.md
# Triggered Multi-Record Capture Sequencer

This block sequences the capture of a sampled parallel data stream into a circular record buffer. Once armed, it waits for a start trigger and then fills a pre-trigger window. After that it listens for a reference trigger and writes the post-trigger samples that complete the record. When more records are requested, it waits for an advance trigger before the next one. The block drives only the write enable and the write address of the buffer. The data path itself runs alongside it, so every write lines up with the sample present in the same cycle.

Each of the four triggers (start, reference, advance, pause) has its own source select, line index and polarity bit. The source can be one of the external lines, a per-trigger software bit, the shared pattern-match pulse, or nothing. Start, reference and advance act on an edge. Pause acts on a level and stops capture in the same cycle it is seen. Ready-for-start and ready-for-advance are level outputs. End-of-record is a one-cycle pulse. The block also reports the latched start address of the last record and the number of records completed.

Top module: `acq_record_ctrl`

## Requirements
- R1: A synchronous reset returns the block to idle. After it, wr_en, rdy_start, rdy_adv and eor are low and rec_cnt is 0.
- R2: An arm pulse in idle clears rec_cnt. When the start source is enabled, rdy_start then stays high until a start edge is seen.
- R3: trig_pol bit i selects the edge or level of trigger i. 1 means a rising edge (or active-high pause), 0 means a falling edge (or active-low pause). An edge of the opposite direction has no effect.
- R4: Trigger i is configured by trig_src[2i+1:2i] and trig_line[2i+1:2i], with i = 0 start, 1 reference, 2 advance, 3 pause. The source codes are: 0 disabled, 1 external line ext_lines[trig_line], 2 software bit sw_trig[i], 3 pat_hit.
- R5: A disabled trigger is not waited for. A disabled start goes from arm straight to capture. A disabled reference fires as soon as the pre-trigger window is full. A disabled advance starts the next record at once. A disabled pause never halts capture.
- R6: Each record writes from address 0 upward and wraps from rec_len-1 to 0. The block does not accept a reference trigger until pre_cnt samples of that record have been written.
- R7: Take the address after the write of the reference cycle, subtract pre_cnt, and reduce modulo rec_len. This value is latched on rec_base. Exactly rec_len-pre_cnt further samples are then written. eor pulses for one cycle, in the cycle after the record's last write.
- R8: While pause is active, wr_en is low and the write address and sample counts hold. Capture resumes at the held address.
- R9: After each eor, rec_cnt has gone up by one. If it is below num_rec, rdy_adv stays high until an advance edge, which starts the next record at address 0. Otherwise the block returns to idle.
- R10: A trigger edge that arrives in a state not waiting for it is dropped and is never acted on later.
- R11: With pre_cnt equal to rec_len, the reference trigger ends the record at once, with no post-trigger write.
- R12: A sample is written only in a cycle where smp_vld is high and the block is capturing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Begin an acquisition session (pulse, honoured in idle) |
| smp_vld | input | 1 | A sample is present this cycle |
| ext_lines | input | NLINE | External trigger lines |
| sw_trig | input | 4 | Software trigger bits, one per trigger |
| pat_hit | input | 1 | Pattern-match detector output |
| trig_src | input | 8 | Source code per trigger, 2 bits each |
| trig_line | input | 4*LSW | External line index per trigger |
| trig_pol | input | 4 | Edge/level polarity per trigger |
| rec_len | input | AW+1 | Record length in samples (1..DEPTH) |
| pre_cnt | input | AW+1 | Pre-trigger samples (0..rec_len) |
| num_rec | input | CW | Records per session |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | AW | Buffer write address |
| rec_base | output | AW | Start address of the last triggered record |
| rdy_start | output | 1 | Waiting for start trigger |
| rdy_adv | output | 1 | Waiting for advance trigger |
| eor | output | 1 | End-of-record pulse |
| rec_cnt | output | CW | Records completed in this session |

## Verification
The bench sends a reference trigger while the pre-trigger window is still filling. A design that queued that edge would close the record early, and eor would rise too soon. It places a reference trigger after the window has wrapped, where a wrong modulo reduction would latch the wrong rec_base. It holds pause in both capture phases, which exposes a design that lets the address drift while paused. It sets pre_cnt equal to rec_len, where a design that writes one post-trigger sample anyway would overwrite the oldest pre-trigger sample. It also drives edges of the opposite polarity and triggers that arrive in idle, both of which a correct design ignores.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSTART,
        ST_PRE,
        ST_ARMED,
        ST_POST,
        ST_WADV
    } acq_st_e;

    localparam logic [1:0] SRC_OFF  = 2'd0;
    localparam logic [1:0] SRC_LINE = 2'd1;
    localparam logic [1:0] SRC_SW   = 2'd2;
    localparam logic [1:0] SRC_PAT  = 2'd3;

    localparam int TRG_START = 0;
    localparam int TRG_REF   = 1;
    localparam int TRG_ADV   = 2;
    localparam int TRG_PAUSE = 3;
    localparam int NUM_TRG   = 4;
endpackage

// File: rtl/acq_trig_sel.sv
module acq_trig_sel
    import acq_pkg::*;
#(
    parameter int NLINE = 4,
    parameter int LSW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_i,
    input  logic [LSW-1:0]   line_i,
    input  logic             pol_i,
    input  logic [NLINE-1:0] lines_i,
    input  logic             sw_i,
    input  logic             pat_i,
    output logic             edge_o,
    output logic             act_o
);
    logic raw;
    logic prev_d, prev_q;

    always_comb begin
        case (src_i)
            SRC_LINE: raw = lines_i[line_i];
            SRC_SW:   raw = sw_i;
            SRC_PAT:  raw = pat_i;
            default:  raw = 1'b0;
        endcase
        prev_d = raw;
        edge_o = pol_i ? (raw & ~prev_q) : (~raw & prev_q);
        act_o  = (src_i != SRC_OFF) && (raw == pol_i);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/acq_rec_seq.sv
module acq_rec_seq
    import acq_pkg::*;
#(
    parameter int AW = 6,
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          vld_i,
    input  logic          start_ev_i,
    input  logic          ref_ev_i,
    input  logic          adv_ev_i,
    input  logic          start_en_i,
    input  logic          ref_en_i,
    input  logic          adv_en_i,
    input  logic          pause_i,
    input  logic [AW:0]   rec_len_i,
    input  logic [AW:0]   pre_i,
    input  logic [CW-1:0] nrec_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rdy_start_o,
    output logic          rdy_adv_o,
    output logic          eor_o,
    output logic [AW-1:0] base_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        acq_st_e       st;
        logic [AW-1:0] wptr;
        logic [AW:0]   fill;
        logic [AW:0]   left;
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
        logic          eor;
    } seq_t;

    seq_t q, d;
    logic          cap, wr, fin;
    logic [AW-1:0] wnext;
    logic [AW:0]   wn_ext, fill_n, post_n, base_w;
    logic [CW-1:0] cnt_n;

    always_comb begin
        d      = q;
        d.eor  = 1'b0;
        fin    = 1'b0;
        cap    = (q.st == ST_PRE) || (q.st == ST_ARMED) || (q.st == ST_POST);
        wr     = cap && vld_i && !pause_i;
        if (!wr)                              wnext = q.wptr;
        else if ({1'b0, q.wptr} == rec_len_i - 1'b1) wnext = '0;
        else                                  wnext = q.wptr + 1'b1;
        wn_ext = {1'b0, wnext};
        fill_n = q.fill + {{AW{1'b0}}, wr};
        post_n = rec_len_i - pre_i;
        base_w = (wn_ext >= pre_i) ? (wn_ext - pre_i) : (wn_ext + rec_len_i - pre_i);
        cnt_n  = q.cnt + {{(CW-1){1'b0}}, 1'b1};

        case (q.st)
            ST_IDLE: if (arm_i) begin
                d.cnt  = '0;
                d.wptr = '0;
                d.fill = '0;
                d.st   = start_en_i ? ST_WSTART : ST_PRE;
            end
            ST_WSTART: if (start_ev_i) begin
                d.wptr = '0;
                d.fill = '0;
                d.st   = ST_PRE;
            end
            ST_PRE: begin
                d.wptr = wnext;
                d.fill = fill_n;
                if (fill_n >= pre_i) d.st = ST_ARMED;
            end
            ST_ARMED: begin
                d.wptr = wnext;
                if (ref_ev_i || !ref_en_i) begin
                    d.base = base_w[AW-1:0];
                    d.left = post_n;
                    if (post_n == '0) fin = 1'b1;
                    else              d.st = ST_POST;
                end
            end
            ST_POST: begin
                d.wptr = wnext;
                if (wr) begin
                    d.left = q.left - 1'b1;
                    if (q.left == {{AW{1'b0}}, 1'b1}) fin = 1'b1;
                end
            end
            ST_WADV: if (adv_ev_i) begin
                d.wptr = '0;
                d.fill = '0;
                d.st   = ST_PRE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (fin) begin
            d.eor = 1'b1;
            d.cnt = cnt_n;
            if (cnt_n >= nrec_i) begin
                d.st = ST_IDLE;
            end else if (adv_en_i) begin
                d.st = ST_WADV;
            end else begin
                d.wptr = '0;
                d.fill = '0;
                d.st   = ST_PRE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign wr_en_o     = wr;
    assign wr_addr_o   = q.wptr;
    assign rdy_start_o = (q.st == ST_WSTART);
    assign rdy_adv_o   = (q.st == ST_WADV);
    assign eor_o       = q.eor;
    assign base_o      = q.base;
    assign cnt_o       = q.cnt;

    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_i && cap && !fin) |=> $stable(q.wptr));

    // R9
    eor_count_chk: assert property (@(posedge clk) disable iff (rst)
        eor_o |-> (cnt_o == $past(cnt_o) + {{(CW-1){1'b0}}, 1'b1}));

    // R9
    adv_after_eor_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_adv_o) |-> eor_o);

    // R6
    armed_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_ARMED) |-> (q.fill >= pre_i));

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st != ST_IDLE) |-> ({1'b0, q.wptr} < rec_len_i));

    // R2
    start_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_start_o |-> !wr_en_o);
endmodule

// File: rtl/acq_record_ctrl.sv
module acq_record_ctrl
    import acq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NLINE = 4,
    parameter int CW    = 31,
    parameter int AW    = $clog2(DEPTH),
    parameter int LSW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   arm,
    input  logic                   smp_vld,
    input  logic [NLINE-1:0]       ext_lines,
    input  logic [NUM_TRG-1:0]     sw_trig,
    input  logic                   pat_hit,
    input  logic [2*NUM_TRG-1:0]   trig_src,
    input  logic [LSW*NUM_TRG-1:0] trig_line,
    input  logic [NUM_TRG-1:0]     trig_pol,
    input  logic [AW:0]            rec_len,
    input  logic [AW:0]            pre_cnt,
    input  logic [CW-1:0]          num_rec,
    output logic                   wr_en,
    output logic [AW-1:0]          wr_addr,
    output logic [AW-1:0]          rec_base,
    output logic                   rdy_start,
    output logic                   rdy_adv,
    output logic                   eor,
    output logic [CW-1:0]          rec_cnt
);
    logic [NUM_TRG-1:0] ev, act, en;

    for (genvar i = 0; i < NUM_TRG; i++) begin : g_trig
        assign en[i] = (trig_src[2*i +: 2] != SRC_OFF);
        acq_trig_sel #(.NLINE(NLINE), .LSW(LSW)) u_sel (
            .clk     (clk),
            .rst     (rst),
            .src_i   (trig_src[2*i +: 2]),
            .line_i  (trig_line[LSW*i +: LSW]),
            .pol_i   (trig_pol[i]),
            .lines_i (ext_lines),
            .sw_i    (sw_trig[i]),
            .pat_i   (pat_hit),
            .edge_o  (ev[i]),
            .act_o   (act[i])
        );
    end

    acq_rec_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .vld_i       (smp_vld),
        .start_ev_i  (ev[TRG_START]),
        .ref_ev_i    (ev[TRG_REF]),
        .adv_ev_i    (ev[TRG_ADV]),
        .start_en_i  (en[TRG_START]),
        .ref_en_i    (en[TRG_REF]),
        .adv_en_i    (en[TRG_ADV]),
        .pause_i     (act[TRG_PAUSE]),
        .rec_len_i   (rec_len),
        .pre_i       (pre_cnt),
        .nrec_i      (num_rec),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .rdy_start_o (rdy_start),
        .rdy_adv_o   (rdy_adv),
        .eor_o       (eor),
        .base_o      (rec_base),
        .cnt_o       (rec_cnt)
    );
endmodule

// File: tb/tb_acq_record_ctrl.sv
module tb_acq_record_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        smp_vld = 1'b0;
    logic [3:0]  ext_lines = '0;
    logic [3:0]  sw_trig = '0;
    logic        pat_hit = 1'b0;
    logic [7:0]  trig_src = '0;
    logic [7:0]  trig_line = '0;
    logic [3:0]  trig_pol = '0;
    logic [6:0]  rec_len = 7'd4;
    logic [6:0]  pre_cnt = 7'd2;
    logic [30:0] num_rec = 31'd2;
    logic        wr_en, rdy_start, rdy_adv, eor;
    logic [5:0]  wr_addr, rec_base;
    logic [30:0] rec_cnt;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    acq_record_ctrl dut (
        .clk(clk), .rst(rst), .arm(arm), .smp_vld(smp_vld), .ext_lines(ext_lines),
        .sw_trig(sw_trig), .pat_hit(pat_hit), .trig_src(trig_src), .trig_line(trig_line),
        .trig_pol(trig_pol), .rec_len(rec_len), .pre_cnt(pre_cnt), .num_rec(num_rec),
        .wr_en(wr_en), .wr_addr(wr_addr), .rec_base(rec_base), .rdy_start(rdy_start),
        .rdy_adv(rdy_adv), .eor(eor), .rec_cnt(rec_cnt)
    );

    typedef struct packed {
        logic       arm;
        logic       vld;
        logic [2:0] sw;
        logic       we;
        logic [5:0] addr;
        logic       rs;
        logic       ra;
        logic       eor;
    } vec_t;

    // two records, rec_len 4, pre 2, start/ref/adv from software bits, rising edge
    localparam vec_t VEC [21] = '{
        '{1'b1, 1'b0, 3'b000, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 3'b001, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b010, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b010, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 3'b000, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 3'b100, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 3'b010, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b1, 6'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 3'b001, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'b000, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        // table config: start/ref/adv = software (2), pause off
        trig_src = {2'd0, 2'd2, 2'd2, 2'd2};
        trig_pol = 4'b0111;
        repeat (3) step();
        settle();
        chk("R1 wr_en", wr_en, 0);
        chk("R1 rdy_start", rdy_start, 0);
        chk("R1 rdy_adv", rdy_adv, 0);
        chk("R1 eor", eor, 0);
        chk("R1 rec_cnt", rec_cnt, 0);
        step();
        rst = 1'b0;

        for (int i = 0; i < 21; i++) begin
            step();
            arm = VEC[i].arm;
            smp_vld = VEC[i].vld;
            sw_trig = {1'b0, VEC[i].sw};
            settle();
            chk(i >= 19 ? "R10 wr_en" : "R12 wr_en", wr_en, VEC[i].we);
            if (VEC[i].we) chk("R6 wr_addr", wr_addr, VEC[i].addr);
            chk("R2 rdy_start", rdy_start, VEC[i].rs);
            chk("R9 rdy_adv", rdy_adv, VEC[i].ra);
            chk(i >= 19 ? "R10 eor" : "R7 eor", eor, VEC[i].eor);
            if (i == 8)  chk("R7 rec_base wrap", rec_base, 3);
            if (i == 11) chk("R9 rec_cnt first", rec_cnt, 1);
            if (i == 16) chk("R7 rec_base second", rec_base, 0);
            if (i == 18) chk("R9 rec_cnt last", rec_cnt, 2);
        end

        // pause on line 2 active low, ref on line 1 falling, start/adv disabled
        step();
        arm = 1'b0; smp_vld = 1'b0; sw_trig = '0;
        rec_len = 7'd3; pre_cnt = 7'd1; num_rec = 31'd1;
        trig_src = {2'd1, 2'd0, 2'd1, 2'd0};
        trig_line = {2'd2, 2'd0, 2'd1, 2'd0};
        trig_pol = 4'b0000;
        ext_lines = 4'b0110;
        repeat (2) step();
        arm = 1'b1;
        step();
        arm = 1'b0; smp_vld = 1'b1; ext_lines = 4'b0010;
        settle();
        chk("R5 start disabled rdy_start", rdy_start, 0);
        chk("R8 paused wr_en", wr_en, 0);
        step();
        ext_lines = 4'b0110;
        settle();
        chk("R8 resume wr_en", wr_en, 1);
        chk("R8 resume addr", wr_addr, 0);
        step();
        ext_lines = 4'b0100;
        settle();
        chk("R4 line ref cycle write", wr_en, 1);
        chk("R4 line ref cycle addr", wr_addr, 1);
        step();
        ext_lines = 4'b0000;
        settle();
        chk("R8 post paused wr_en", wr_en, 0);
        step();
        ext_lines = 4'b0100;
        settle();
        chk("R8 held addr", wr_addr, 2);
        chk("R8 post resume wr_en", wr_en, 1);
        step();
        settle();
        chk("R6 wrap addr", wr_addr, 0);
        chk("R7 last write", wr_en, 1);
        step();
        smp_vld = 1'b0;
        settle();
        chk("R7 eor", eor, 1);
        chk("R7 rec_base", rec_base, 1);
        chk("R9 single record count", rec_cnt, 1);
        chk("R9 no advance wait", rdy_adv, 0);

        // start on line 0 rising, ref on pattern rising, pre == rec_len
        step();
        rec_len = 7'd2; pre_cnt = 7'd2; num_rec = 31'd1;
        trig_src = {2'd0, 2'd0, 2'd3, 2'd1};
        trig_line = '0;
        trig_pol = 4'b0011;
        ext_lines = 4'b0001;
        repeat (2) step();
        arm = 1'b1;
        step();
        arm = 1'b0; ext_lines = 4'b0000;
        settle();
        chk("R2 rdy_start", rdy_start, 1);
        step();
        ext_lines = 4'b0001;
        settle();
        chk("R3 falling edge ignored", rdy_start, 1);
        step();
        pat_hit = 1'b1; smp_vld = 1'b1;
        settle();
        chk("R3 rising start", rdy_start, 0);
        chk("R6 pre write addr", wr_addr, 0);
        step();
        pat_hit = 1'b0;
        settle();
        chk("R6 pre write", wr_en, 1);
        step();
        settle();
        chk("R10 early ref not queued eor", eor, 0);
        chk("R6 circular addr", wr_addr, 0);
        step();
        pat_hit = 1'b1;
        settle();
        chk("R10 still armed eor", eor, 0);
        chk("R4 pattern ref cycle addr", wr_addr, 1);
        step();
        pat_hit = 1'b0; smp_vld = 1'b0;
        settle();
        chk("R11 eor after ref", eor, 1);
        chk("R11 no post write", wr_en, 0);
        chk("R11 rec_base", rec_base, 0);
        step();
        settle();
        chk("R7 eor one cycle", eor, 0);

        // reset while waiting for start
        trig_src = {2'd0, 2'd2, 2'd2, 2'd2};
        trig_pol = 4'b0111;
        step();
        arm = 1'b1;
        step();
        arm = 1'b0;
        settle();
        chk("R2 armed rdy_start", rdy_start, 1);
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        settle();
        chk("R1 reset rdy_start", rdy_start, 0);
        chk("R1 reset rec_cnt", rec_cnt, 0);
        chk("R1 reset eor", eor, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule